// File: doc/BRIEF.md
# Hang Watchdog with Frequency Fallback

This block supervises a clock synthesizer whose frequency can be changed by software. A bad setting may leave the system hung, so software arms a down-counter before trying a new frequency. The counter counts in units of a slow supervisory tick, nominally 250 ms, which comes from outside the block and is derived from the reference clock. If software does not re-arm or stop the counter before it runs out, the block drives a reset line low for a fixed number of ticks. It also turns off the divisor programming mode and forces the frequency code to a known-good value.

The known-good value is one of two things. It is the frequency code captured from the board straps at power-up, or a software-supplied safe code. A safe-enable bit chooses between them. While the timer runs, software can read the remaining count through the depth read-back, plus a running bit and a sticky expiry flag. The reset output is an open-drain enable: when it is 1 the pad pulls the line low, and when it is 0 the line is released.

Top module: `wdg_guard`

## Requirements
- R1: After reset the depth read-back is 8 and the safe code is 00010. Running, the expiry flag, the reset drive, the software-select bit, the safe-enable bit and the divisor-mode bit are all 0. The effective frequency code equals the strap input.
- R2: A control write with arm=1 sets running in the next cycle, clears the expiry flag, stores the safe code, and starts the count at the configured depth.
- R3: While running, each tick with no write in the same cycle lowers the depth read-back (the live count) by one.
- R4: With depth N ≥ 1, the N-th tick after arming ends the count. In the next cycle running is 0, the expiry flag is 1, and the depth read-back again shows the configured depth.
- R5: The reset drive goes to 1 in the cycle after expiry. It stays 1 until the PULSE_TICKS-th following tick (default 1), then returns to 0.
- R6: On expiry the divisor-mode bit is cleared.
- R7: On expiry the frequency code is loaded with the strap value when safe-enable is 0, or with the safe code when safe-enable is 1. The software-select bit is set to 1. The effective frequency code is the stored code when software-select is 1, and the strap value otherwise.
- R8: A depth write while running restarts the count from the written value and keeps the expiry flag at 0. A depth write while idle only changes the configured depth and leaves the flag as it was.
- R9: After an expiry, further ticks change neither the outputs nor the count. No second reset pulse occurs until software arms the timer again.
- R10: A control write with arm=0 stops the count with no expiry actions: no flag, no reset pulse, no change to the frequency code.
- R11: A control or depth write in the same cycle as the expiring tick takes priority and no expiry occurs. A frequency-register write in the same cycle as an expiry is discarded.
- R12: Arming with a depth of 0 expires on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle supervisory tick (one count unit) |
| strap_fsel_i | input | 5 | Frequency code captured from straps at power-up |
| depth_wr_i | input | 1 | Depth register write strobe |
| depth_wdata_i | input | CNT_W | Depth value to write |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_arm_i | input | 1 | Control write: 1 arms, 0 stops |
| ctl_safe_i | input | 5 | Control write: safe frequency code |
| freq_wr_i | input | 1 | Frequency register write strobe |
| freq_sw_en_i | input | 1 | Write data: software frequency select |
| freq_code_i | input | 5 | Write data: frequency code |
| freq_safe_en_i | input | 1 | Write data: use the safe code on expiry |
| freq_mn_en_i | input | 1 | Write data: divisor programming mode |
| depth_rd_o | output | CNT_W | Live count while running, configured depth otherwise |
| run_o | output | 1 | Timer is counting |
| tmo_flag_o | output | 1 | Sticky expiry flag |
| safe_code_o | output | 5 | Stored safe frequency code |
| sw_en_o | output | 1 | Software frequency select in force |
| fsel_code_o | output | 5 | Stored software frequency code |
| safe_en_o | output | 1 | Safe-code fallback selected |
| mn_en_o | output | 1 | Divisor programming mode |
| eff_fsel_o | output | 5 | Frequency code in effect |
| rst_drive_o | output | 1 | Open-drain enable: 1 pulls the reset line low |

## Verification
The hardest cases to reach are the ones where a write and the expiring tick land on the same edge. The bench reaches them by counting the timer down to 1 through the ports, then issuing the tick together with a control write, and elsewhere together with a frequency write. The outcome is read in the following cycle from the flag, the reset drive and the frequency code. The same countdown-to-1 approach is used to show that a depth write during a run restarts the count, and that a reset pulse spans exactly one tick period.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned FSEL_W = 5;

    typedef logic [FSEL_W-1:0] fsel_t;

    // software-visible frequency control register
    typedef struct packed {
        logic  sw_en;
        fsel_t code;
        logic  safe_en;
        logic  mn_en;
    } freq_cfg_t;

    // code restored when the watchdog runs out
    function automatic fsel_t fallback_code(input logic safe_en,
                                            input fsel_t safe,
                                            input fsel_t strap);
        return safe_en ? safe : strap;
    endfunction

endpackage

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int unsigned CNT_W     = 7,
    parameter int unsigned DEPTH_RST = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             depth_wr_i,
    input  logic [CNT_W-1:0] depth_wdata_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_arm_i,
    output logic [CNT_W-1:0] depth_rd_o,
    output logic             run_o,
    output logic             flag_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] DEPTH_INIT = CNT_W'(DEPTH_RST);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    logic [CNT_W-1:0] depth_cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             flag_q;

    // a pending write of either kind overrides the expiring tick
    assign expire_o   = run_q && tick_i && (cnt_q <= ONE) && !depth_wr_i && !ctl_wr_i;
    assign depth_rd_o = run_q ? cnt_q : depth_cfg_q;
    assign run_o      = run_q;
    assign flag_o     = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_cfg_q <= DEPTH_INIT;
            cnt_q       <= '0;
            run_q       <= 1'b0;
            flag_q      <= 1'b0;
        end else begin
            if (depth_wr_i) begin
                depth_cfg_q <= depth_wdata_i;
                if (run_q) begin
                    cnt_q  <= depth_wdata_i;
                    flag_q <= 1'b0;
                end
            end
            if (ctl_wr_i) begin
                if (ctl_arm_i) begin
                    run_q  <= 1'b1;
                    flag_q <= 1'b0;
                    cnt_q  <= depth_wr_i ? depth_wdata_i : depth_cfg_q;
                end else begin
                    run_q <= 1'b0;
                end
            end else if (expire_o) begin
                run_q  <= 1'b0;
                flag_q <= 1'b1;
                cnt_q  <= '0;
            end else if (run_q && tick_i && !depth_wr_i) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
    parameter int unsigned PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic start_i,
    output logic drive_o
);
    localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_TICKS);

    logic [PW-1:0] left_q;

    assign drive_o = (left_q != '0);

    // the start edge is itself a tick, so it loads rather than counts
    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= LOAD;
        end else if (tick_i && drive_o) begin
            left_q <= left_q - PW'(1);
        end
    end
endmodule

// File: rtl/wdg_freqsel.sv
module wdg_freqsel
    import wdg_pkg::*;
#(
    parameter logic [FSEL_W-1:0] FSEL_RST = 5'b00010,
    parameter logic [FSEL_W-1:0] SAFE_RST = 5'b00010
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      expire_i,
    input  fsel_t     strap_i,
    input  logic      freq_wr_i,
    input  freq_cfg_t freq_wdata_i,
    input  logic      safe_wr_i,
    input  fsel_t     safe_wdata_i,
    output freq_cfg_t cfg_o,
    output fsel_t     safe_o,
    output fsel_t     eff_o
);
    freq_cfg_t cfg_q;
    fsel_t     safe_q;

    assign cfg_o  = cfg_q;
    assign safe_o = safe_q;
    assign eff_o  = cfg_q.sw_en ? cfg_q.code : strap_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{sw_en: 1'b0, code: FSEL_RST, safe_en: 1'b0, mn_en: 1'b0};
            safe_q <= SAFE_RST;
        end else begin
            if (safe_wr_i) begin
                safe_q <= safe_wdata_i;
            end
            if (expire_i) begin
                cfg_q.mn_en <= 1'b0;
                cfg_q.sw_en <= 1'b1;
                cfg_q.code  <= fallback_code(cfg_q.safe_en, safe_q, strap_i);
            end else if (freq_wr_i) begin
                cfg_q <= freq_wdata_i;
            end
        end
    end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W       = 7,
    parameter int unsigned DEPTH_RST   = 8,
    parameter int unsigned PULSE_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [4:0]       strap_fsel_i,
    input  logic             depth_wr_i,
    input  logic [CNT_W-1:0] depth_wdata_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_arm_i,
    input  logic [4:0]       ctl_safe_i,
    input  logic             freq_wr_i,
    input  logic             freq_sw_en_i,
    input  logic [4:0]       freq_code_i,
    input  logic             freq_safe_en_i,
    input  logic             freq_mn_en_i,
    output logic [CNT_W-1:0] depth_rd_o,
    output logic             run_o,
    output logic             tmo_flag_o,
    output logic [4:0]       safe_code_o,
    output logic             sw_en_o,
    output logic [4:0]       fsel_code_o,
    output logic             safe_en_o,
    output logic             mn_en_o,
    output logic [4:0]       eff_fsel_o,
    output logic             rst_drive_o
);
    logic      expire;
    freq_cfg_t freq_wdata;
    freq_cfg_t cfg;

    assign freq_wdata = '{sw_en: freq_sw_en_i, code: freq_code_i,
                          safe_en: freq_safe_en_i, mn_en: freq_mn_en_i};

    wdg_countdown #(.CNT_W(CNT_W), .DEPTH_RST(DEPTH_RST)) cnt_i (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .depth_wr_i   (depth_wr_i),
        .depth_wdata_i(depth_wdata_i),
        .ctl_wr_i     (ctl_wr_i),
        .ctl_arm_i    (ctl_arm_i),
        .depth_rd_o   (depth_rd_o),
        .run_o        (run_o),
        .flag_o       (tmo_flag_o),
        .expire_o     (expire)
    );

    wdg_pulse #(.PULSE_TICKS(PULSE_TICKS)) pulse_i (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .start_i(expire),
        .drive_o(rst_drive_o)
    );

    wdg_freqsel fsel_i (
        .clk         (clk),
        .rst         (rst),
        .expire_i    (expire),
        .strap_i     (strap_fsel_i),
        .freq_wr_i   (freq_wr_i),
        .freq_wdata_i(freq_wdata),
        .safe_wr_i   (ctl_wr_i),
        .safe_wdata_i(ctl_safe_i),
        .cfg_o       (cfg),
        .safe_o      (safe_code_o),
        .eff_o       (eff_fsel_o)
    );

    assign sw_en_o     = cfg.sw_en;
    assign fsel_code_o = cfg.code;
    assign safe_en_o   = cfg.safe_en;
    assign mn_en_o     = cfg.mn_en;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             depth_wr_i,
    input logic             ctl_wr_i,
    input logic             ctl_arm_i,
    input logic [CNT_W-1:0] depth_rd_o,
    input logic             run_o,
    input logic             tmo_flag_o,
    input logic             sw_en_o,
    input logic             mn_en_o,
    input logic             rst_drive_o
);
    a_r2_arm_starts: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr_i && ctl_arm_i) |=> (run_o && !tmo_flag_o));

    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (run_o && tick_i && !depth_wr_i && !ctl_wr_i && depth_rd_o > CNT_W'(1))
        |=> (run_o && depth_rd_o == $past(depth_rd_o) - CNT_W'(1)));

    a_r4_flag_from_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag_o) |-> ($past(run_o) && $past(tick_i) && !run_o));

    a_r5_pulse_on_expiry: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_drive_o) |-> $rose(tmo_flag_o));

    a_r6_r7_mode_fallback: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag_o) |-> (!mn_en_o && sw_en_o));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!run_o && !ctl_wr_i && !depth_wr_i)
        |=> (!run_o && $stable(depth_rd_o) && $stable(tmo_flag_o)));
endmodule

bind wdg_guard wdg_guard_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/wdg_guard_tb_top.sv
module wdg_guard_tb_top;
    localparam int CNT_W = 7;
    localparam int STRAP = 13;

    localparam int S_DEPTH = 0, S_RUN = 1, S_FLAG = 2, S_OE = 3, S_SAFE = 4,
                   S_SWEN = 5, S_FSEL = 6, S_SAFEEN = 7, S_MN = 8, S_EFF = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_i = 1'b0;
    logic [4:0]       strap_fsel_i = 5'(STRAP);
    logic             depth_wr_i = 1'b0;
    logic [CNT_W-1:0] depth_wdata_i = '0;
    logic             ctl_wr_i = 1'b0;
    logic             ctl_arm_i = 1'b0;
    logic [4:0]       ctl_safe_i = '0;
    logic             freq_wr_i = 1'b0;
    logic             freq_sw_en_i = 1'b0;
    logic [4:0]       freq_code_i = '0;
    logic             freq_safe_en_i = 1'b0;
    logic             freq_mn_en_i = 1'b0;
    logic [CNT_W-1:0] depth_rd_o;
    logic             run_o, tmo_flag_o, sw_en_o, safe_en_o, mn_en_o, rst_drive_o;
    logic [4:0]       safe_code_o, fsel_code_o, eff_fsel_o;

    always #4 clk = ~clk;

    wdg_guard dut_i (.*);

    typedef struct {
        string req;
        int    sel;
        int    exp;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    function automatic int obs(input int sel);
        case (sel)
            S_DEPTH:  return int'(depth_rd_o);
            S_RUN:    return int'(run_o);
            S_FLAG:   return int'(tmo_flag_o);
            S_OE:     return int'(rst_drive_o);
            S_SAFE:   return int'(safe_code_o);
            S_SWEN:   return int'(sw_en_o);
            S_FSEL:   return int'(fsel_code_o);
            S_SAFEEN: return int'(safe_en_o);
            S_MN:     return int'(mn_en_o);
            default:  return int'(eff_fsel_o);
        endcase
    endfunction

    // monitor: compare queued expectations after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() != 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (obs(it.sel) != it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%0d expected=%0d",
                             it.req, it.sel, obs(it.sel), it.exp);
                end
            end
        end
    end

    task automatic ex(input string r, input int s, input int e);
        q.push_back('{r, s, e});
    endtask

    task automatic step();
        @(negedge clk);
        tick_i = 0; depth_wr_i = 0; ctl_wr_i = 0; freq_wr_i = 0;
    endtask

    task automatic set_depth(input int d);
        depth_wr_i = 1; depth_wdata_i = CNT_W'(d);
    endtask

    task automatic set_ctl(input bit arm, input int safe);
        ctl_wr_i = 1; ctl_arm_i = arm; ctl_safe_i = 5'(safe);
    endtask

    task automatic set_freq(input bit sw, input int code, input bit se, input bit mn);
        freq_wr_i = 1; freq_sw_en_i = sw; freq_code_i = 5'(code);
        freq_safe_en_i = se; freq_mn_en_i = mn;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        ex("R1", S_DEPTH, 8); ex("R1", S_RUN, 0); ex("R1", S_FLAG, 0); ex("R1", S_OE, 0);
        ex("R1", S_SAFE, 2); ex("R1", S_SWEN, 0); ex("R1", S_SAFEEN, 0); ex("R1", S_MN, 0);
        ex("R1", S_EFF, STRAP);
        step();
        set_freq(0, 7, 0, 1);
        ex("R7", S_MN, 1); ex("R7", S_FSEL, 7); ex("R7", S_EFF, STRAP);
        step();
        set_depth(3);                                   // R8 idle write
        ex("R8", S_DEPTH, 3); ex("R8", S_RUN, 0);
        step();
        set_ctl(1, 22);                                 // R2 arm
        ex("R2", S_RUN, 1); ex("R2", S_DEPTH, 3); ex("R2", S_FLAG, 0); ex("R2", S_SAFE, 22);
        step();
        tick_i = 1; ex("R3", S_DEPTH, 2); ex("R3", S_RUN, 1); step();
        tick_i = 1; ex("R3", S_DEPTH, 1); step();
        tick_i = 1;                                     // R4/R6/R7 strap fallback
        ex("R4", S_RUN, 0); ex("R4", S_FLAG, 1); ex("R4", S_DEPTH, 3); ex("R5", S_OE, 1);
        ex("R6", S_MN, 0); ex("R7", S_SWEN, 1); ex("R7", S_FSEL, STRAP); ex("R7", S_EFF, STRAP);
        step();
        for (int i = 0; i < 3; i++) begin
            ex("R5", S_OE, 1); step();
        end
        tick_i = 1; ex("R5", S_OE, 0); step();
        tick_i = 1;                                     // R9 no second action
        ex("R9", S_OE, 0); ex("R9", S_FLAG, 1); ex("R9", S_RUN, 0); ex("R9", S_DEPTH, 3);
        step();
        set_freq(0, 1, 1, 1);
        ex("R7", S_SAFEEN, 1); ex("R7", S_FSEL, 1); ex("R7", S_EFF, STRAP);
        step();
        set_depth(4);
        ex("R8", S_DEPTH, 4); ex("R8", S_FLAG, 1); ex("R8", S_RUN, 0);
        step();
        set_ctl(1, 22);
        ex("R2", S_RUN, 1); ex("R2", S_FLAG, 0); ex("R2", S_DEPTH, 4);
        step();
        tick_i = 1; ex("R3", S_DEPTH, 3); step();
        set_depth(5);                                   // R8 restart while running
        ex("R8", S_DEPTH, 5); ex("R8", S_RUN, 1); ex("R8", S_FLAG, 0);
        step();
        tick_i = 1; ex("R8", S_DEPTH, 4); step();
        tick_i = 1; ex("R3", S_DEPTH, 3); step();
        tick_i = 1; ex("R3", S_DEPTH, 2); step();
        tick_i = 1; ex("R3", S_DEPTH, 1); step();
        tick_i = 1;                                     // R7 safe-code fallback
        ex("R4", S_RUN, 0); ex("R4", S_FLAG, 1); ex("R7", S_FSEL, 22); ex("R7", S_SWEN, 1);
        ex("R6", S_MN, 0); ex("R7", S_EFF, 22); ex("R5", S_OE, 1); ex("R4", S_DEPTH, 5);
        step();
        tick_i = 1; ex("R5", S_OE, 0); step();
        set_depth(2); ex("R8", S_DEPTH, 2); step();
        set_ctl(1, 22); ex("R2", S_RUN, 1); ex("R2", S_DEPTH, 2); step();
        tick_i = 1; ex("R3", S_DEPTH, 1); step();
        tick_i = 1; set_freq(0, 3, 1, 1);               // R11 frequency write loses
        ex("R11", S_RUN, 0); ex("R11", S_FLAG, 1); ex("R11", S_MN, 0); ex("R11", S_SWEN, 1);
        ex("R11", S_FSEL, 22); ex("R11", S_OE, 1);
        step();
        tick_i = 1; ex("R5", S_OE, 0); step();
        set_ctl(1, 22); ex("R2", S_RUN, 1); ex("R2", S_FLAG, 0); ex("R2", S_DEPTH, 2); step();
        tick_i = 1; ex("R3", S_DEPTH, 1); step();
        tick_i = 1; set_ctl(1, 22);                     // R11 re-arm wins
        ex("R11", S_RUN, 1); ex("R11", S_DEPTH, 2); ex("R11", S_FLAG, 0); ex("R11", S_OE, 0);
        step();
        set_ctl(0, 22);                                 // R10 stop
        ex("R10", S_RUN, 0); ex("R10", S_FLAG, 0); ex("R10", S_OE, 0); ex("R10", S_DEPTH, 2);
        step();
        tick_i = 1;
        ex("R10", S_RUN, 0); ex("R10", S_FLAG, 0); ex("R10", S_OE, 0); ex("R10", S_FSEL, 22);
        step();
        set_depth(0); ex("R12", S_DEPTH, 0); step();
        set_ctl(1, 22); ex("R12", S_RUN, 1); ex("R12", S_DEPTH, 0); step();
        tick_i = 1;
        ex("R12", S_RUN, 0); ex("R12", S_FLAG, 1); ex("R12", S_OE, 1);
        step();
        step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule